// File: doc/BRIEF.md
# Mailbox Command Sender Engine

This block is a bus master that carries one command through a shared-memory mailbox and collects the answer. A caller pulses `start` with a transaction ID, a command code, an argument count, the argument words, an urgent flag and the number of payload words it is able to take. The engine builds a command header and checks that the request is well formed. It then reads the free pointer of the command ring and writes the header and the arguments into the ring. After that it publishes the new valid pointer and writes the outbound doorbell.

For a normal command the engine polls the return doorbell and clears it. It compares the response read and valid pointers, fetches one response header and advances the read pointer. Headers that carry a different client or transaction ID are dropped, and the engine goes back to waiting. A matching header either reports its error field or announces a payload. The engine consumes every word of that payload, but only the first words up to the caller's capacity are passed to the output stream. An urgent command sets the urgent register before the doorbell. It expects no response and reads an acknowledge bit from the status register instead. Every request ends with a one-cycle `done` pulse that carries a result code.

Top module: `mbox_cmd_engine`

## Requirements
- R1: The command header is {client ID[31:28], transaction ID[27:24], 0 at bit 23, argument count[22:12], 0 at bit 11, command code[10:0]}. The client ID is a parameter (default 4'hB).
- R2: A request whose argument count plus one exceeds CMD_DEPTH (32), or whose command code exceeds 2047, ends with result INVALID and makes no bus access. Count 31 with code 2047 is accepted.
- R3: The first bus access is a read of the free-pointer register (address 0x08). A value of CMD_DEPTH or more ends the request with result NOSPACE and no write.
- R4: The header is written to the command ring at 0x40 + p, where p is the free pointer. Argument k is written to 0x40 + ((p+1+k) mod 32). Then the next index is written to the valid-pointer register (0x00), and then 1 is written to the outbound doorbell (0x80), in that order.
- R5: For an urgent command, 1 is written to the urgent register (0x02) before the doorbell. After the return doorbell, 0 is written to it and the status register (0x0B) is read. Bit 8 set gives result OK, clear gives NOACK. No word of the response ring (0x60..0x6F) is read.
- R6: The return doorbell (0x81, bit 0) is cleared by writing 0. The response read pointer (0x01) and valid pointer (0x09) are read. If they differ, the word at 0x60 + read pointer is read and the read pointer, advanced modulo 16, is written back.
- R7: A response header whose bits [31:28] differ from the client ID, or whose bits [27:24] differ from the transaction ID, is discarded and the doorbell wait restarts. A matching header with nonzero bits [10:0] ends with result RESPERR, and `done_err` carries those bits.
- R8: A matching header with error 0 announces bits [22:12] payload words. Each word is awaited until the valid pointer differs from the read pointer, then read, and the read pointer is written back. All words are consumed, and only the first `req_cap` words appear on `out_valid`/`out_data`, in order.
- R9: Result TIMEOUT is reported when the return doorbell stays clear for LONG_TO cycles, or when a payload word does not arrive within SHORT_TO cycles.
- R10: `done` is high for exactly one cycle per request. The result codes are 0 OK, 1 INVALID, 2 NOSPACE, 3 TIMEOUT, 4 NOACK, 5 RESPERR, and `done_err` is 0 except for RESPERR.
- R11: `bus_req` stays high with stable address, direction and write data until the cycle in which `bus_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Starts a request; sampled only while idle |
| req_id | input | 4 | Transaction ID |
| req_cmd | input | 16 | Command code (valid up to 2047) |
| req_len | input | 8 | Argument word count |
| req_args | input | (CMD_DEPTH-1)*32 | Argument words, word k at bits [32k+31:32k] |
| req_urgent | input | 1 | Send as urgent command |
| req_cap | input | 8 | Payload words the caller accepts |
| busy | output | 1 | Request in progress |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | 8 | Word address |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access completed this cycle |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| out_valid | output | 1 | Payload word valid |
| out_data | output | 32 | Payload word |
| done | output | 1 | One-cycle completion pulse |
| done_code | output | 3 | Result code |
| done_err | output | 11 | Error field returned by the far side |

## Verification
The bench builds the engine with LONG_TO at 200 cycles and SHORT_TO at 40 cycles. With these values both timeout paths, the silent doorbell and the stalled payload word, finish within a few hundred cycles. The ring depths stay at their defaults of 32 and 16. This keeps the real wrap points in reach: a command starting at free index 30, a full 31-argument command that wraps the valid pointer back to 0, and a response that crosses index 15. The bus model adds wait states on one test to exercise holding a request.

// File: rtl/mbox_pkg.sv
// Shared constants for the mailbox command engine: register word
// addresses seen by the engine and the result codes on its done port.
package mbox_pkg;
    localparam int AW = 8;
    localparam logic [AW-1:0] A_VALID   = 8'h00;
    localparam logic [AW-1:0] A_RPTR    = 8'h01;
    localparam logic [AW-1:0] A_URG     = 8'h02;
    localparam logic [AW-1:0] A_FREE    = 8'h08;
    localparam logic [AW-1:0] A_VPTR    = 8'h09;
    localparam logic [AW-1:0] A_STAT    = 8'h0B;
    localparam logic [AW-1:0] A_CMD     = 8'h40;
    localparam logic [AW-1:0] A_RSP     = 8'h60;
    localparam logic [AW-1:0] A_DB_OUT  = 8'h80;
    localparam logic [AW-1:0] A_DB_IN   = 8'h81;
    localparam logic [15:0]   MAX_CMD   = 16'd2047;

    typedef enum logic [2:0] {
        RC_OK      = 3'd0,
        RC_INVALID = 3'd1,
        RC_NOSPACE = 3'd2,
        RC_TIMEOUT = 3'd3,
        RC_NOACK   = 3'd4,
        RC_RESPERR = 3'd5
    } rc_e;
endpackage

// File: rtl/mbox_hdr_pack.sv
// Builds the command header word from the request fields and checks that
// the request fits the ring and the command code range.
// Assumes: CMD_DEPTH <= 256; purely combinational.
module mbox_hdr_pack #(
    parameter logic [3:0] CLIENT_ID = 4'hB,
    parameter int         CMD_DEPTH = 32
) (
    input  logic [15:0] cmd,
    input  logic [7:0]  len,
    input  logic [3:0]  id,
    output logic [31:0] hdr,
    output logic        ok
);
    import mbox_pkg::*;

    // Request is legal when header plus arguments fit and the code is in range
    assign ok  = (({1'b0, len} + 9'd1) <= 9'(CMD_DEPTH)) && (cmd <= MAX_CMD);
    // Header layout: client, id, spare, length, indirect flag (0), code
    assign hdr = {CLIENT_ID, id, 1'b0, {3'b000, len}, 1'b0, cmd[10:0]};
endmodule

// File: rtl/mbox_timer.sv
// Down-counting timeout. A load pulse restarts it at LIMIT; expired is
// high once the count has reached zero. Assumes LIMIT > 0.
module mbox_timer #(
    parameter int          W     = 32,
    parameter logic [W-1:0] LIMIT = 32'd1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    logic [W-1:0] count;

    // Reload on request, otherwise count down to zero and hold
    always_ff @(posedge clk) begin
        if (!rst_n)              count <= '0;
        else if (load)           count <= LIMIT;
        else if (count != '0)    count <= count - 1'b1;
    end

    assign expired = (count == '0);

    AST_TMR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !expired);  // R9
endmodule

// File: rtl/mbox_cmd_engine.sv
// Mailbox command sender. Issues one command through the circular command
// ring, rings the doorbell, then either checks the urgent acknowledge or
// reads, filters and drains the response ring. Ends each request with a
// one-cycle done pulse and result code.
// Assumes: CMD_DEPTH and RSP_DEPTH are powers of two (pointer wrap is the
// natural binary wrap); request inputs are valid in the start cycle; the
// bus slave acknowledges every access eventually.
module mbox_cmd_engine #(
    parameter logic [3:0] CLIENT_ID = 4'hB,
    parameter int         CMD_DEPTH = 32,
    parameter int         RSP_DEPTH = 16,
    parameter int         TO_W      = 32,
    parameter int         LONG_TO   = 50_000_000,
    parameter int         SHORT_TO  = 5_000_000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [3:0]                 req_id,
    input  logic [15:0]                req_cmd,
    input  logic [7:0]                 req_len,
    input  logic [(CMD_DEPTH-1)*32-1:0] req_args,
    input  logic                       req_urgent,
    input  logic [7:0]                 req_cap,
    output logic                       busy,
    output logic                       bus_req,
    output logic                       bus_we,
    output logic [7:0]                 bus_addr,
    output logic [31:0]                bus_wdata,
    input  logic                       bus_ack,
    input  logic [31:0]                bus_rdata,
    output logic                       out_valid,
    output logic [31:0]                out_data,
    output logic                       done,
    output logic [2:0]                 done_code,
    output logic [10:0]                done_err
);
    import mbox_pkg::*;

    localparam int MAX_ARGS = CMD_DEPTH - 1;
    localparam int CPW      = $clog2(CMD_DEPTH);
    localparam int RPW      = $clog2(RSP_DEPTH);

    typedef enum logic [4:0] {
        S_IDLE, S_RD_FREE, S_WR_HDR, S_WR_ARG, S_WR_VALID, S_WR_URG1,
        S_WR_DB, S_POLL_DB, S_CLR_DB, S_WR_URG0, S_RD_STAT, S_RD_RPTR,
        S_RD_VPTR, S_RD_RHDR, S_WR_RPTR_H, S_POLL_VPTR, S_RD_PAY, S_WR_RPTR_P
    } st_e;

    st_e                     state;
    logic [31:0]             hdr_w, hdr_q;
    logic                    hdr_ok;
    logic [MAX_ARGS*32-1:0]  args_q;
    logic [7:0]              len_q, cap_q, fwd_cnt;
    logic [3:0]              id_q;
    logic                    urg_q;
    logic [CPW-1:0]          wptr, idx;
    logic [RPW-1:0]          rptr;
    logic [3:0]              rh_client, rh_id;
    logic [10:0]             rh_err, rh_len, remain;
    logic                    long_load, short_load, long_exp, short_exp;
    wire                     unused_rdata = ^{bus_rdata[23], bus_rdata[11]};

    mbox_hdr_pack #(.CLIENT_ID(CLIENT_ID), .CMD_DEPTH(CMD_DEPTH)) u_pack (
        .cmd(req_cmd), .len(req_len), .id(req_id), .hdr(hdr_w), .ok(hdr_ok)
    );

    mbox_timer #(.W(TO_W), .LIMIT(TO_W'(LONG_TO))) u_long_tmr (
        .clk(clk), .rst_n(rst_n), .load(long_load), .expired(long_exp)
    );

    mbox_timer #(.W(TO_W), .LIMIT(TO_W'(SHORT_TO))) u_short_tmr (
        .clk(clk), .rst_n(rst_n), .load(short_load), .expired(short_exp)
    );

    assign busy = (state != S_IDLE);

    // Bus access decode: each state other than idle owns one access
    always_comb begin
        bus_req   = 1'b1;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        case (state)
            S_IDLE:      bus_req = 1'b0;
            S_RD_FREE:   bus_addr = A_FREE;
            S_WR_HDR:    begin bus_we = 1'b1; bus_addr = A_CMD + AW'(wptr); bus_wdata = hdr_q; end
            S_WR_ARG:    begin bus_we = 1'b1; bus_addr = A_CMD + AW'(wptr); bus_wdata = args_q[idx*32 +: 32]; end
            S_WR_VALID:  begin bus_we = 1'b1; bus_addr = A_VALID; bus_wdata = 32'(wptr); end
            S_WR_URG1:   begin bus_we = 1'b1; bus_addr = A_URG; bus_wdata = 32'd1; end
            S_WR_DB:     begin bus_we = 1'b1; bus_addr = A_DB_OUT; bus_wdata = 32'd1; end
            S_POLL_DB:   bus_addr = A_DB_IN;
            S_CLR_DB:    begin bus_we = 1'b1; bus_addr = A_DB_IN; end
            S_WR_URG0:   begin bus_we = 1'b1; bus_addr = A_URG; end
            S_RD_STAT:   bus_addr = A_STAT;
            S_RD_RPTR:   bus_addr = A_RPTR;
            S_RD_VPTR:   bus_addr = A_VPTR;
            S_RD_RHDR:   bus_addr = A_RSP + AW'(rptr);
            S_WR_RPTR_H: begin bus_we = 1'b1; bus_addr = A_RPTR; bus_wdata = 32'(rptr); end
            S_POLL_VPTR: bus_addr = A_VPTR;
            S_RD_PAY:    bus_addr = A_RSP + AW'(rptr);
            S_WR_RPTR_P: begin bus_we = 1'b1; bus_addr = A_RPTR; bus_wdata = 32'(rptr); end
            default:     bus_req = 1'b0;
        endcase
    end

    // Sequencer: advances on each acknowledged access and reports the result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            done <= 1'b0; done_code <= RC_OK; done_err <= '0;
            out_valid <= 1'b0; out_data <= '0;
            long_load <= 1'b0; short_load <= 1'b0;
            hdr_q <= '0; args_q <= '0; len_q <= '0; cap_q <= '0; id_q <= '0;
            urg_q <= 1'b0; wptr <= '0; idx <= '0; rptr <= '0; fwd_cnt <= '0;
            rh_client <= '0; rh_id <= '0; rh_err <= '0; rh_len <= '0; remain <= '0;
        end else begin
            done <= 1'b0;
            out_valid <= 1'b0;
            long_load <= 1'b0;
            short_load <= 1'b0;
            case (state)
                S_IDLE: if (start) begin
                    hdr_q <= hdr_w; args_q <= req_args; len_q <= req_len;
                    cap_q <= req_cap; id_q <= req_id; urg_q <= req_urgent;
                    fwd_cnt <= '0; done_err <= '0;
                    if (hdr_ok) state <= S_RD_FREE;
                    else begin done <= 1'b1; done_code <= RC_INVALID; end
                end
                S_RD_FREE: if (bus_ack) begin
                    if (bus_rdata >= 32'(CMD_DEPTH)) begin
                        done <= 1'b1; done_code <= RC_NOSPACE; state <= S_IDLE;
                    end else begin
                        wptr <= bus_rdata[CPW-1:0]; idx <= '0; state <= S_WR_HDR;
                    end
                end
                S_WR_HDR: if (bus_ack) begin
                    wptr <= wptr + 1'b1;
                    state <= (len_q == 8'd0) ? S_WR_VALID : S_WR_ARG;
                end
                S_WR_ARG: if (bus_ack) begin
                    wptr <= wptr + 1'b1;
                    idx <= idx + 1'b1;
                    if (8'(idx) + 8'd1 == len_q) state <= S_WR_VALID;
                end
                S_WR_VALID: if (bus_ack) state <= urg_q ? S_WR_URG1 : S_WR_DB;
                S_WR_URG1:  if (bus_ack) state <= S_WR_DB;
                S_WR_DB: if (bus_ack) begin
                    long_load <= 1'b1; state <= S_POLL_DB;
                end
                S_POLL_DB: if (bus_ack) begin
                    if (bus_rdata[0]) state <= S_CLR_DB;
                    else if (long_exp && !long_load) begin
                        done <= 1'b1; done_code <= RC_TIMEOUT; state <= S_IDLE;
                    end
                end
                S_CLR_DB:  if (bus_ack) state <= urg_q ? S_WR_URG0 : S_RD_RPTR;
                S_WR_URG0: if (bus_ack) state <= S_RD_STAT;
                S_RD_STAT: if (bus_ack) begin
                    done <= 1'b1; state <= S_IDLE;
                    done_code <= bus_rdata[8] ? RC_OK : RC_NOACK;
                end
                S_RD_RPTR: if (bus_ack) begin
                    rptr <= bus_rdata[RPW-1:0]; state <= S_RD_VPTR;
                end
                S_RD_VPTR: if (bus_ack) begin
                    if (bus_rdata[RPW-1:0] != rptr) state <= S_RD_RHDR;
                    else begin long_load <= 1'b1; state <= S_POLL_DB; end
                end
                S_RD_RHDR: if (bus_ack) begin
                    rh_client <= bus_rdata[31:28]; rh_id <= bus_rdata[27:24];
                    rh_len <= bus_rdata[22:12]; rh_err <= bus_rdata[10:0];
                    rptr <= rptr + 1'b1; state <= S_WR_RPTR_H;
                end
                S_WR_RPTR_H: if (bus_ack) begin
                    if (rh_client != CLIENT_ID || rh_id != id_q) begin
                        long_load <= 1'b1; state <= S_POLL_DB;
                    end else if (rh_err != '0) begin
                        done <= 1'b1; done_code <= RC_RESPERR; done_err <= rh_err;
                        state <= S_IDLE;
                    end else if (rh_len == '0) begin
                        done <= 1'b1; done_code <= RC_OK; state <= S_IDLE;
                    end else begin
                        remain <= rh_len; short_load <= 1'b1; state <= S_POLL_VPTR;
                    end
                end
                S_POLL_VPTR: if (bus_ack) begin
                    if (bus_rdata[RPW-1:0] != rptr) state <= S_RD_PAY;
                    else if (short_exp && !short_load) begin
                        done <= 1'b1; done_code <= RC_TIMEOUT; state <= S_IDLE;
                    end
                end
                S_RD_PAY: if (bus_ack) begin
                    rptr <= rptr + 1'b1;
                    remain <= remain - 1'b1;
                    if (fwd_cnt < cap_q) begin
                        out_valid <= 1'b1; out_data <= bus_rdata;
                        fwd_cnt <= fwd_cnt + 1'b1;
                    end
                    state <= S_WR_RPTR_P;
                end
                S_WR_RPTR_P: if (bus_ack) begin
                    if (remain == '0) begin
                        done <= 1'b1; done_code <= RC_OK; state <= S_IDLE;
                    end else begin
                        short_load <= 1'b1; state <= S_POLL_VPTR;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));  // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R10
    AST_FWD_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_cnt <= cap_q);  // R8
    AST_INVALID_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start && !hdr_ok) |=> (done && done_code == RC_INVALID && !bus_req));  // R2
    AST_URG_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && urg_q) |-> !(bus_req && bus_addr >= A_RSP && bus_addr < A_RSP + AW'(RSP_DEPTH)));  // R5
endmodule

// File: tb/mbox_cmd_engine_test.sv
module mbox_cmd_engine_test;
    localparam int CLK_NS = 10;
    localparam int NARG   = 31;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, req_urgent = 1'b0;
    logic [3:0] req_id = '0;
    logic [15:0] req_cmd = '0;
    logic [7:0] req_len = '0, req_cap = '0;
    logic [NARG*32-1:0] req_args = '0;
    logic busy, bus_req, bus_we, bus_ack = 1'b0, out_valid, done;
    logic [7:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata = '0, out_data;
    logic [2:0] done_code;
    logic [10:0] done_err;

    mbox_cmd_engine #(.LONG_TO(200), .SHORT_TO(40)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .req_id(req_id), .req_cmd(req_cmd),
        .req_len(req_len), .req_args(req_args), .req_urgent(req_urgent), .req_cap(req_cap),
        .busy(busy), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .out_valid(out_valid), .out_data(out_data), .done(done),
        .done_code(done_code), .done_err(done_err)
    );

    always #(CLK_NS/2) clk = ~clk;

    int n_checks = 0, n_fail = 0, cycles = 0;
    logic [31:0] regs [0:255];
    logic [7:0]  wr_addr [0:255];
    logic [31:0] wr_data [0:255];
    int wr_n, rsp_reads, outs_n, done_n, extra_db, lat, wait_cnt, unstable;
    bit answer;
    logic [31:0] outs [0:63];
    logic [2:0] got_code;
    logic [10:0] got_err;
    logic [7:0] held_addr;

    // Register-bus slave and far-side model, all on the falling edge
    always @(negedge clk) begin
        cycles++;
        if (out_valid && outs_n < 64) begin outs[outs_n] = out_data; outs_n++; end
        if (done) begin done_n++; got_code = done_code; got_err = done_err; end
        if (bus_ack) bus_ack = 1'b0;
        else if (bus_req) begin
            if (wait_cnt == 0) held_addr = bus_addr;
            else if (held_addr != bus_addr) unstable++;
            if (wait_cnt < lat) wait_cnt++;
            else begin
                wait_cnt = 0;
                bus_ack = 1'b1;
                if (bus_we) begin
                    regs[bus_addr] = bus_wdata;
                    if (wr_n < 256) begin wr_addr[wr_n] = bus_addr; wr_data[wr_n] = bus_wdata; wr_n++; end
                    if (bus_addr == 8'h80 && bus_wdata[0] && answer) regs[8'h81] = 32'd1;
                    if (bus_addr == 8'h81 && bus_wdata == 0 && extra_db > 0) begin
                        regs[8'h81] = 32'd1; extra_db--;
                    end
                end else begin
                    bus_rdata = regs[bus_addr];
                    if (bus_addr >= 8'h60 && bus_addr < 8'h70) rsp_reads++;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (cycles > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: act=%0d cycles exp<=150000", cycles);
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    task automatic clear_env();
        for (int i = 0; i < 256; i++) regs[i] = '0;
        wr_n = 0; rsp_reads = 0; outs_n = 0; done_n = 0; extra_db = 0;
        answer = 1'b1; lat = 0; wait_cnt = 0; unstable = 0;
    endtask

    function automatic logic [31:0] rsp_hdr(input logic [3:0] cl, input logic [3:0] id,
                                            input int len, input int err);
        return {cl, id, 1'b0, 11'(len), 1'b0, 11'(err)};
    endfunction

    function automatic int find_wr(input logic [7:0] a, input logic [31:0] d);
        for (int i = 0; i < wr_n; i++) if (wr_addr[i] == a && wr_data[i] == d) return i;
        return -1;
    endfunction

    task automatic run(input logic [3:0] id, input logic [15:0] cmd, input int len,
                       input bit urg, input int cap);
        @(negedge clk);
        req_id = id; req_cmd = cmd; req_len = 8'(len); req_urgent = urg; req_cap = 8'(cap);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 5000 && done_n == 0; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check(done == 0 && bus_req == 0 && out_valid == 0 && busy == 0,
              "R10 reset idle", {done, bus_req, out_valid, busy}, 0);
    endtask

    task automatic t_normal_wrap();
        clear_env();
        lat = 2;
        regs[8'h08] = 30;
        regs[8'h01] = 14; regs[8'h09] = 1;
        regs[8'h6E] = rsp_hdr(4'hB, 4'h3, 2, 0);
        regs[8'h6F] = 32'h1111_0000; regs[8'h60] = 32'h2222_0000;
        for (int k = 0; k < 3; k++) req_args[k*32 +: 32] = 32'hA000_0000 + k;
        run(4'h3, 16'h123, 3, 1'b0, 5);
        check(done_n == 1 && got_code == 0, "R10 normal ok", got_code, 0);
        check(wr_addr[0] == 8'h5E && wr_data[0] == {4'hB, 4'h3, 1'b0, 11'd3, 1'b0, 11'h123},
              "R1 header word at free index 30", wr_data[0], {4'hB, 4'h3, 1'b0, 11'd3, 1'b0, 11'h123});
        check(wr_addr[1] == 8'h5F && wr_addr[2] == 8'h40 && wr_addr[3] == 8'h41 &&
              wr_data[3] == 32'hA000_0002, "R4 args wrap mod 32", wr_addr[2], 8'h40);
        check(wr_addr[4] == 8'h00 && wr_data[4] == 2 && wr_addr[5] == 8'h80,
              "R4 valid pointer then doorbell", wr_data[4], 2);
        check(find_wr(8'h81, 0) > 5, "R6 return doorbell cleared", find_wr(8'h81, 0), 6);
        check(outs_n == 2 && outs[0] == 32'h1111_0000 && outs[1] == 32'h2222_0000,
              "R8 payload forwarded in order", outs_n, 2);
        check(regs[8'h01] == 1, "R6 read pointer wraps mod 16", regs[8'h01], 1);
        check(unstable == 0, "R11 request held stable under wait states", unstable, 0);
    endtask

    task automatic t_invalid();
        clear_env();
        run(4'h1, 16'd5, 32, 1'b0, 0);
        check(done_n == 1 && got_code == 1, "R2 count 32 invalid", got_code, 1);
        check(wr_n == 0 && busy == 0, "R2 no bus access", wr_n, 0);
        clear_env();
        run(4'h1, 16'd2048, 0, 1'b0, 0);
        check(got_code == 1 && wr_n == 0, "R2 code 2048 invalid", got_code, 1);
    endtask

    task automatic t_full_resperr();
        clear_env();
        regs[8'h08] = 0; regs[8'h01] = 0; regs[8'h09] = 1;
        regs[8'h60] = rsp_hdr(4'hB, 4'h7, 0, 3);
        for (int k = 0; k < NARG; k++) req_args[k*32 +: 32] = 32'hC000_0000 + k;
        run(4'h7, 16'd2047, 31, 1'b0, 0);
        check(got_code == 5 && got_err == 3, "R7 returned error 3", {got_code, got_err}, {3'd5, 11'd3});
        check(find_wr(8'h5F, 32'hC000_001E) >= 0 && regs[8'h00] == 0,
              "R2 count 31 accepted, R4 valid pointer wraps to 0", regs[8'h00], 0);
    endtask

    task automatic t_nospace();
        clear_env();
        regs[8'h08] = 32;
        run(4'h2, 16'd9, 1, 1'b0, 0);
        check(got_code == 2 && wr_n == 0, "R3 free pointer 32 no space", got_code, 2);
    endtask

    task automatic t_urgent();
        clear_env();
        regs[8'h0B] = 32'h100;
        regs[8'h09] = 3;
        run(4'h4, 16'd2, 0, 1'b1, 4);
        check(got_code == 0 && got_err == 0, "R5 urgent ack ok", got_code, 0);
        check(find_wr(8'h02, 1) >= 0 && find_wr(8'h02, 1) < find_wr(8'h80, 1),
              "R5 urgent set before doorbell", find_wr(8'h02, 1), find_wr(8'h80, 1));
        check(find_wr(8'h02, 0) > find_wr(8'h81, 0) && find_wr(8'h81, 0) > 0,
              "R5 urgent cleared after doorbell clear", find_wr(8'h02, 0), find_wr(8'h81, 0) + 1);
        check(rsp_reads == 0 && outs_n == 0, "R5 no response read", rsp_reads, 0);
        clear_env();
        regs[8'h0B] = 32'h0FF;
        run(4'h4, 16'd2, 0, 1'b1, 0);
        check(got_code == 4, "R5 missing ack", got_code, 4);
    endtask

    task automatic t_filter();
        clear_env();
        extra_db = 2;
        regs[8'h01] = 5; regs[8'h09] = 8;
        regs[8'h65] = rsp_hdr(4'hA, 4'h6, 0, 9);
        regs[8'h66] = rsp_hdr(4'hB, 4'h5, 0, 9);
        regs[8'h67] = rsp_hdr(4'hB, 4'h6, 0, 0);
        run(4'h6, 16'd50, 0, 1'b0, 0);
        check(got_code == 0 && got_err == 0, "R7 foreign headers dropped", {got_code, got_err}, 0);
        check(regs[8'h01] == 8 && rsp_reads == 3, "R7 all three consumed", regs[8'h01], 8);
    endtask

    task automatic t_cap();
        clear_env();
        regs[8'h01] = 0; regs[8'h09] = 5;
        regs[8'h60] = rsp_hdr(4'hB, 4'h9, 4, 0);
        for (int k = 1; k <= 4; k++) regs[8'h60 + k] = 32'hD000_0000 + k;
        run(4'h9, 16'd59, 0, 1'b0, 2);
        check(got_code == 0 && outs_n == 2, "R8 forwarded only capacity", outs_n, 2);
        check(outs[0] == 32'hD000_0001 && outs[1] == 32'hD000_0002, "R8 first words kept", outs[1], 32'hD000_0002);
        check(regs[8'h01] == 5 && rsp_reads == 5, "R8 whole payload drained", regs[8'h01], 5);
    endtask

    task automatic t_timeouts();
        clear_env();
        answer = 1'b0;
        run(4'h1, 16'd51, 0, 1'b0, 0);
        check(got_code == 3 && rsp_reads == 0, "R9 doorbell timeout", got_code, 3);
        clear_env();
        regs[8'h01] = 0; regs[8'h09] = 1;
        regs[8'h60] = rsp_hdr(4'hB, 4'h1, 2, 0);
        run(4'h1, 16'd51, 0, 1'b0, 4);
        check(got_code == 3 && outs_n == 0, "R9 payload poll timeout", got_code, 3);
    endtask

    initial begin
        clear_env();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_normal_wrap();
        t_invalid();
        t_full_resperr();
        t_nospace();
        t_urgent();
        t_filter();
        t_cap();
        t_timeouts();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule